// File: doc/BRIEF.md
# Output Compare Waveform Generator

This block turns a time-base count, supplied from outside, into one output waveform. A 4-bit mode input selects the behaviour. In timer-only mode the pin is left alone. The three single-edge modes drive the pin high, drive it low or toggle it when the count equals compare value A. The two dual-edge modes raise the pin when the count hits compare A and drop it when the count hits compare B, which produces pulse and PWM shapes. One mode disables the generator and forwards an external signal to the pin.

The count and compare inputs are twice the base width. The single-edge modes can use the full width when the wide select is set. Otherwise they use only the lower half. The dual-edge modes always use the lower half. The buffered dual-edge mode keeps its own copy of both compare values and loads new ones only on the time base's rollover pulse. Software can therefore rewrite the compare inputs in the middle of a period without a glitch. Every result is registered, so a decision made in one cycle appears at the pin on the following cycle.

Top module: `ocw_wavegen`

## Requirements
- R1: After reset, and in the cycle after any cycle in which `enable` is low, `wave_out` is 0.
- R2: In mode 0000 (timer only), `wave_out` keeps its value.
- R3: In mode 0001, `wave_out` becomes 1 in the cycle after count equals `cmp_a`, and otherwise keeps its value.
- R4: In mode 0010, `wave_out` becomes 0 in the cycle after count equals `cmp_a`, and otherwise keeps its value.
- R5: In mode 0011, `wave_out` inverts in the cycle after count equals `cmp_a`, and otherwise keeps its value.
- R6: In modes 0001 to 0011 with `wide` = 1, the comparison uses all 2*BASE_W bits. With `wide` = 0, it uses only bits [BASE_W-1:0], and the upper bits have no effect.
- R7: In mode 0100, a match of the low BASE_W bits of count with `cmp_a` sets the output, and a match with `cmp_b` clears it. When both match in the same cycle, the clear wins. `wide` is ignored.
- R8: Mode 0101 behaves like mode 0100 but compares against held copies of `cmp_a`/`cmp_b`. The copies load in any cycle where `rollover` is 1, and also in any cycle where the block is disabled or in another mode. A new value is used from the cycle after it loads.
- R9: In mode 1111, `wave_out` equals the value `ext_in` had one cycle earlier.
- R10: In the reserved modes 0110 to 1110, `wave_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Module on; low forces output low |
| mode | input | 4 | Operating mode code |
| wide | input | 1 | Full-width compare for single-edge modes |
| count | input | 2*BASE_W | Time-base count |
| rollover | input | 1 | Time-base period rollover pulse |
| cmp_a | input | 2*BASE_W | Compare value A (set/single-edge) |
| cmp_b | input | 2*BASE_W | Compare value B (clear, dual-edge) |
| ext_in | input | 1 | External signal forwarded in mode 1111 |
| wave_out | output | 1 | Generated waveform |

## Verification
Every result reaches `wave_out` one clock edge after the inputs that cause it. The only exception is a buffered compare value: it loads on the rollover edge and then affects the pin one edge later, two edges in all. The bench changes inputs on the falling edge. It advances a model of the requirements on the same rising edge as the design and samples `wave_out` 1 ns later, so every cycle of a sweep is checked. The sweeps move the compare values in mid-period to separate the buffered and unbuffered modes.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
   localparam logic [3:0] MD_TIMER   = 4'd0;
   localparam logic [3:0] MD_SET     = 4'd1;
   localparam logic [3:0] MD_CLR     = 4'd2;
   localparam logic [3:0] MD_TGL     = 4'd3;
   localparam logic [3:0] MD_DUAL    = 4'd4;
   localparam logic [3:0] MD_DUALBUF = 4'd5;
   localparam logic [3:0] MD_EXT     = 4'd15;

   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_SET,
      ACT_CLR,
      ACT_TGL,
      ACT_EXT,
      ACT_ZERO
   } ocw_act_e;
endpackage

// File: rtl/ocw_match.sv
module ocw_match #(
   parameter int BASE_W  = 16,
   parameter bit WIDE_OK = 1'b1,
   localparam int CW     = 2 * BASE_W
) (
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] cmp,
   input  logic          wide,
   output logic          hit
);
   logic lo_eq;
   assign lo_eq = (count[BASE_W-1:0] == cmp[BASE_W-1:0]);

   generate
      if (WIDE_OK) begin : g_wide
         logic hi_eq;
         assign hi_eq = (count[CW-1:BASE_W] == cmp[CW-1:BASE_W]);
         assign hit   = lo_eq && (!wide || hi_eq);
      end else begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^{wide, count[CW-1:BASE_W], cmp[CW-1:BASE_W]};
         assign hit       = lo_eq;
      end
   endgenerate
endmodule

// File: rtl/ocw_shadow.sv
module ocw_shadow #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din_a,
   input  logic [W-1:0] din_b,
   output logic [W-1:0] q_a,
   output logic [W-1:0] q_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_a <= '0;
         q_b <= '0;
      end else if (load) begin
         q_a <= din_a;
         q_b <= din_b;
      end
   end
endmodule

// File: rtl/ocw_drive.sv
module ocw_drive
   import ocw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ocw_act_e act,
   input  logic     ext_in,
   output logic     pin
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin <= 1'b0;
      end else begin
         case (act)
            ACT_SET:  pin <= 1'b1;
            ACT_CLR:  pin <= 1'b0;
            ACT_ZERO: pin <= 1'b0;
            ACT_TGL:  pin <= ~pin;
            ACT_EXT:  pin <= ext_in;
            default:  pin <= pin;
         endcase
      end
   end
endmodule

// File: rtl/ocw_wavegen.sv
module ocw_wavegen
   import ocw_pkg::*;
#(
   parameter int BASE_W  = 16,
   parameter bit WIDE_OK = 1'b1,
   localparam int CW     = 2 * BASE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [3:0]    mode,
   input  logic          wide,
   input  logic [CW-1:0] count,
   input  logic          rollover,
   input  logic [CW-1:0] cmp_a,
   input  logic [CW-1:0] cmp_b,
   input  logic          ext_in,
   output logic          wave_out
);
   generate
      if (BASE_W < 2) begin : g_bad_width
         $error("ocw_wavegen: BASE_W must be at least 2");
      end
   endgenerate

   logic          buf_mode;
   logic          shadow_load;
   logic [CW-1:0] held_a, held_b;
   logic [CW-1:0] use_a, use_b;
   logic          hit_single, hit_da, hit_db;
   ocw_act_e      act;

   assign buf_mode    = (mode == MD_DUALBUF);
   assign shadow_load = !enable || !buf_mode || rollover;

   ocw_shadow #(.W(CW)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (shadow_load),
      .din_a (cmp_a),
      .din_b (cmp_b),
      .q_a   (held_a),
      .q_b   (held_b)
   );

   assign use_a = buf_mode ? held_a : cmp_a;
   assign use_b = buf_mode ? held_b : cmp_b;

   ocw_match #(.BASE_W(BASE_W), .WIDE_OK(WIDE_OK)) u_hit_single (
      .count (count), .cmp (cmp_a), .wide (wide), .hit (hit_single)
   );
   ocw_match #(.BASE_W(BASE_W), .WIDE_OK(WIDE_OK)) u_hit_da (
      .count (count), .cmp (use_a), .wide (1'b0), .hit (hit_da)
   );
   ocw_match #(.BASE_W(BASE_W), .WIDE_OK(WIDE_OK)) u_hit_db (
      .count (count), .cmp (use_b), .wide (1'b0), .hit (hit_db)
   );

   always_comb begin
      act = ACT_HOLD;
      if (!enable) begin
         act = ACT_ZERO;
      end else begin
         case (mode)
            MD_SET:  if (hit_single) act = ACT_SET;
            MD_CLR:  if (hit_single) act = ACT_CLR;
            MD_TGL:  if (hit_single) act = ACT_TGL;
            MD_DUAL, MD_DUALBUF: begin
               if (hit_db)      act = ACT_CLR;
               else if (hit_da) act = ACT_SET;
            end
            MD_EXT:  act = ACT_EXT;
            default: act = ACT_HOLD;
         endcase
      end
   end

   ocw_drive u_drive (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act),
      .ext_in (ext_in),
      .pin    (wave_out)
   );
endmodule

// File: rtl/ocw_chk.sv
module ocw_chk #(
   parameter int BASE_W = 16,
   localparam int CW    = 2 * BASE_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable,
   input logic [3:0]    mode,
   input logic          wide,
   input logic [CW-1:0] count,
   input logic [CW-1:0] cmp_a,
   input logic          ext_in,
   input logic          wave_out
);
   logic lo_a;
   assign lo_a = (count[BASE_W-1:0] == cmp_a[BASE_W-1:0]);

   // R1
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !wave_out);

   // R2
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 4'd0) |=> $stable(wave_out));

   // R3
   set_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 4'd1 && !wide && lo_a) |=> wave_out);

   // R4
   clr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 4'd2 && !wide && lo_a) |=> !wave_out);

   // R5
   tgl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 4'd3 && !wide && lo_a) |=> (wave_out != $past(wave_out)));

   // R9
   ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 4'd15) |=> (wave_out == $past(ext_in)));

   // R10
   rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode >= 4'd6 && mode <= 4'd14) |=> $stable(wave_out));
endmodule

bind ocw_wavegen ocw_chk #(.BASE_W(BASE_W)) u_ocw_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .mode     (mode),
   .wide     (wide),
   .count    (count),
   .cmp_a    (cmp_a),
   .ext_in   (ext_in),
   .wave_out (wave_out)
);

// File: tb/ocw_wavegen_bench.sv
module ocw_wavegen_bench;
   localparam int BW = 4;
   localparam int CW = 2 * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [3:0]    mode = '0;
   logic          wide = 1'b0;
   logic [CW-1:0] count = '0;
   logic          rollover = 1'b0;
   logic [CW-1:0] cmp_a = '0;
   logic [CW-1:0] cmp_b = '0;
   logic          ext_in = 1'b0;
   logic          wave_out;

   int total = 0;
   int bad   = 0;
   logic          exp_q = 1'b0;
   logic [CW-1:0] sh_a = '0, sh_b = '0;

   always #5 clk = ~clk;

   ocw_wavegen #(.BASE_W(BW), .WIDE_OK(1'b1)) u_ocw_wavegen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .wide(wide),
      .count(count), .rollover(rollover), .cmp_a(cmp_a), .cmp_b(cmp_b),
      .ext_in(ext_in), .wave_out(wave_out)
   );

   function automatic string req_name(logic en, logic [3:0] md, logic w);
      if (!en) return "R1";
      case (md)
         4'd0: return "R2";
         4'd1: return w ? "R6/R3" : "R3";
         4'd2: return w ? "R6/R4" : "R4";
         4'd3: return w ? "R6/R5" : "R5";
         4'd4: return "R7";
         4'd5: return "R8";
         4'd15: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(string rq, logic act, logic expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: wave_out=%0b expected=%0b (mode=%0d count=%0d)",
                  rq, act, expv, mode, count);
      end
   endtask

   // model of the requirements, evaluated with the inputs seen at the edge
   task automatic model_edge();
      logic lo_a, full_a, hit_s, da, db;
      lo_a   = (count[BW-1:0] == cmp_a[BW-1:0]);
      full_a = (count == cmp_a);
      hit_s  = wide ? full_a : lo_a;
      if (mode == 4'd5) begin
         da = (count[BW-1:0] == sh_a[BW-1:0]);
         db = (count[BW-1:0] == sh_b[BW-1:0]);
      end else begin
         da = lo_a;
         db = (count[BW-1:0] == cmp_b[BW-1:0]);
      end
      if (!enable) exp_q = 1'b0;
      else case (mode)
         4'd1: if (hit_s) exp_q = 1'b1;
         4'd2: if (hit_s) exp_q = 1'b0;
         4'd3: if (hit_s) exp_q = ~exp_q;
         4'd4, 4'd5: begin
            if (db) exp_q = 1'b0;
            else if (da) exp_q = 1'b1;
         end
         4'd15: exp_q = ext_in;
         default: ;
      endcase
      if (!enable || mode != 4'd5 || rollover) begin
         sh_a = cmp_a;
         sh_b = cmp_b;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", wave_out, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int md = 0; md < 16; md++) begin
         for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 256; c++) begin
               int k;
               logic [BW-1:0] alo, blo;
               @(negedge clk);
               k        = ((c + 8) >> 4) & 15;
               alo      = BW'((k * 5 + 2) & 15);
               blo      = (k == 9) ? alo : BW'((k * 5 + 8) & 15);
               mode     = 4'(md);
               wide     = w[0];
               count    = CW'(c);
               rollover = (c[3:0] == 4'hF);
               cmp_a    = {4'h3, alo};
               cmp_b    = {4'h6, blo};
               enable   = !(c >= 100 && c <= 103);
               ext_in   = c[2] ^ c[5] ^ c[0];
               @(posedge clk);
               model_edge();
               #1;
               check(req_name(enable, mode, wide), wave_out, exp_q);
            end
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule